// File: doc/BRIEF.md
# Interrupt Redirection and Delivery Engine

This block sits between a set of interrupt request lines and the processors that service them. For every pin it keeps a redirection entry (vector, delivery mode, destination, destination mode, trigger style, mask), a pending bit and, for level-style pins, a remote-acknowledge bit. Request events arrive as a number plus a level. Pending, unmasked pins are turned into delivery messages, one pin at a time and lowest pin index first, on a valid/ready output stream.

Edge-style pins lose their pending bit when delivered. Level-style pins keep it, and their remote-acknowledge bit blocks any further delivery until an end-of-interrupt carrying a matching vector clears it. One delivery mode code passes the vector through from an external legacy controller instead of taking it from the entry. The register interface writes a 32-bit half of one entry at a time and reads any half back combinationally. Arbitration runs continuously, so any change that makes a pin eligible leads to a delivery attempt: a write, a request or an end-of-interrupt.

Back-pressure rules: a message is offered with `dlv_valid` and is consumed on a rising edge where `dlv_ready` is also high. While `dlv_ready` is low the offered message and `dlv_valid` are held unchanged and no new pin is selected. A new message may be loaded in the same cycle the previous one is consumed.

Top module: `intr_redirect_engine`

## Requirements
- R1: After reset no message is offered, nothing is pending and every entry reads back with only its mask bit (bit 16 of the low word) set.
- R2: Request number 0 is steered to pin 2. A request number n from 1 to NUM_PINS-1 goes to pin n. Any larger number changes nothing.
- R3: On an edge-style pin (trigger bit 0), a request with level 1 sets the pending bit only if the entry is unmasked. Masked requests are dropped and are not delivered after a later unmask. Delivery clears the pending bit, but a request that lands in the same cycle as that delivery wins, and the pin is delivered again.
- R4: On a level-style pin (trigger bit 1), level 1 sets the pending bit even if the entry is masked, and level 0 clears it. Delivery keeps the pending bit and sets remote-acknowledge (bit 14 of the low word). The pin is not delivered again while that bit is set.
- R5: An end-of-interrupt clears remote-acknowledge on every entry whose vector field equals the broadcast vector. Entries with another vector are untouched. A cleared pin that is still pending and unmasked is delivered again.
- R6: When several pins are eligible (pending, unmasked, and not blocked by remote-acknowledge), the lowest index is delivered first.
- R7: Low word layout: vector in bits 7:0, delivery mode in 10:8, destination mode in bit 11, trigger in bit 15, mask in bit 16. Destination sits in bits 31:24 of the high word. The message carries these fields of the selected entry.
- R8: With delivery mode 3'b111 the message vector is taken from `ext_vector`, and `ext_ack` is high for exactly the cycle in which that message is loaded.
- R9: While `dlv_valid` is high and `dlv_ready` is low, the message stays valid and all payload fields hold. Each accepted beat carries one delivery.
- R10: Remote-acknowledge cannot be written from the register interface, and unused bits read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Request event strobe |
| irq_num | input | REQ_W | Request number |
| irq_level | input | 1 | Request level, 1 asserted |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| tbl_wr_en | input | 1 | Entry half write strobe |
| tbl_wr_idx | input | IDX_W | Entry index to write |
| tbl_wr_hi | input | 1 | 1 selects the high word |
| tbl_wr_data | input | 32 | Write data |
| tbl_rd_idx | input | IDX_W | Entry index to read |
| tbl_rd_hi | input | 1 | 1 selects the high word |
| tbl_rd_data | output | 32 | Read data, combinational |
| ext_vector | input | 8 | Vector supplied by the external legacy controller |
| ext_ack | output | 1 | Acknowledge to the external controller |
| dlv_valid | output | 1 | Delivery message valid |
| dlv_ready | input | 1 | Delivery message accepted |
| dlv_dest | output | 8 | Destination |
| dlv_dest_mode | output | 1 | Destination mode |
| dlv_mode | output | 3 | Delivery mode |
| dlv_vector | output | 8 | Vector |
| dlv_trig | output | 1 | Trigger style, 1 level |

## Verification
The collision that matters most is a new request on an edge-style pin arriving in the same cycle as that pin's delivery: the bench holds the request for two consecutive cycles, so the second one lands on the loading edge, and it expects two deliveries of that pin. The second overlap is delivery arbitration against a held output: the bench stalls `dlv_ready` while further requests arrive on lower and higher pins. It then checks that the held payload stays stable and that, once released, the beats follow in ascending pin order.

// File: rtl/intr_redirect_pkg.sv
package intr_redirect_pkg;
  localparam int VEC_W  = 8;
  localparam int DEST_W = 8;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] DM_EXTPASS = 3'b111;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              mask;
    logic              trig;
    logic              dmode;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
  } rte_t;

  typedef struct packed {
    logic [DEST_W-1:0] dest;
    logic              dmode;
    logic [MODE_W-1:0] mode;
    logic [VEC_W-1:0]  vec;
    logic              trig;
  } msg_t;

  localparam rte_t RTE_RESET = '{dest: '0, mask: 1'b1, trig: 1'b0,
                                 dmode: 1'b0, mode: '0, vec: '0};
endpackage

// File: rtl/intr_rte_table.sv
module intr_rte_table
  import intr_redirect_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic                wr_hi,
  input  logic [31:0]         wr_data,
  input  logic                rack_set,
  input  logic [IDX_W-1:0]    rack_idx,
  input  logic                eoi_valid,
  input  logic [VEC_W-1:0]    eoi_vector,
  input  logic [IDX_W-1:0]    rd_idx,
  input  logic                rd_hi,
  output logic [31:0]         rd_data,
  output rte_t                ent_o [NUM_PINS],
  output logic [NUM_PINS-1:0] rack_o
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic wr_hit, set_hit, eoi_hit;
    assign wr_hit  = wr_en && (wr_idx == IDX_W'(i));
    assign set_hit = rack_set && (rack_idx == IDX_W'(i));
    assign eoi_hit = eoi_valid && (ent_o[i].vec == eoi_vector);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ent_o[i] <= RTE_RESET;
      end else if (wr_hit) begin
        if (wr_hi) begin
          ent_o[i].dest <= wr_data[31:24];
        end else begin
          ent_o[i].vec   <= wr_data[7:0];
          ent_o[i].mode  <= wr_data[10:8];
          ent_o[i].dmode <= wr_data[11];
          ent_o[i].trig  <= wr_data[15];
          ent_o[i].mask  <= wr_data[16];
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rst_n)       rack_o[i] <= 1'b0;
      else if (set_hit) rack_o[i] <= 1'b1;
      else if (eoi_hit) rack_o[i] <= 1'b0;
    end

    // R5: a matching end-of-interrupt leaves the bit cleared
    assert_eoi_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && rack_o[i] && ent_o[i].vec == eoi_vector && !set_hit) |=> !rack_o[i]);
    // R10: register writes never raise remote-acknowledge
    assert_rack_ro_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!rack_o[i] && !set_hit) |=> !rack_o[i]);
  end

  always_comb begin
    rte_t re;
    logic rk;
    re = '0;
    rk = 1'b0;
    if (int'(rd_idx) < NUM_PINS) begin
      re = ent_o[rd_idx];
      rk = rack_o[rd_idx];
    end
    if (rd_hi) rd_data = {re.dest, 24'h0};
    else       rd_data = {15'h0, re.mask, re.trig, rk, 2'b00, re.dmode, re.mode, re.vec};
  end

  // R4: a level delivery marks its entry as awaiting acknowledge
  assert_rack_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rack_set |=> rack_o[$past(rack_idx)]);
endmodule

// File: rtl/intr_pending.sv
module intr_pending #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS),
  parameter int REQ_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                irq_valid,
  input  logic [REQ_W-1:0]    irq_num,
  input  logic                irq_level,
  input  logic [NUM_PINS-1:0] trig,
  input  logic [NUM_PINS-1:0] mask,
  input  logic                dclr_en,
  input  logic [IDX_W-1:0]    dclr_idx,
  output logic [NUM_PINS-1:0] pend_o
);
  logic [REQ_W-1:0] pin_num;
  logic             in_range;

  // request 0 is steered onto pin 2
  assign pin_num  = (irq_num == '0) ? REQ_W'(2) : irq_num;
  assign in_range = int'(pin_num) < NUM_PINS;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pend
    logic hit, set_i, lclr_i, dclr_i;
    assign hit    = irq_valid && in_range && (pin_num == REQ_W'(i));
    assign set_i  = hit && irq_level && (trig[i] || !mask[i]);
    assign lclr_i = hit && trig[i] && !irq_level;
    assign dclr_i = dclr_en && (dclr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n)                 pend_o[i] <= 1'b0;
      else if (set_i)             pend_o[i] <= 1'b1;
      else if (lclr_i || dclr_i)  pend_o[i] <= 1'b0;
    end

    // R3: an edge request on a masked pin leaves the pending bit alone
    assert_masked_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !trig[i] && mask[i] && !dclr_i) |=> pend_o[i] == $past(pend_o[i]));
    // R3: a request in the delivery cycle keeps the pin pending
    assert_edge_rearm_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (dclr_i && hit && irq_level && !mask[i]) |=> pend_o[i]);
  end
endmodule

// File: rtl/intr_pick.sv
module intr_pick #(
  parameter int NUM_PINS = 24,
  parameter int IDX_W    = $clog2(NUM_PINS)
) (
  input  logic [NUM_PINS-1:0] elig,
  output logic                found,
  output logic [IDX_W-1:0]    idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_PINS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/intr_redirect_engine.sv
module intr_redirect_engine
  import intr_redirect_pkg::*;
#(
  parameter int NUM_PINS = 24,
  parameter int REQ_W    = 8,
  localparam int IDX_W   = $clog2(NUM_PINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_valid,
  input  logic [REQ_W-1:0]  irq_num,
  input  logic              irq_level,
  input  logic              eoi_valid,
  input  logic [7:0]        eoi_vector,
  input  logic              tbl_wr_en,
  input  logic [IDX_W-1:0]  tbl_wr_idx,
  input  logic              tbl_wr_hi,
  input  logic [31:0]       tbl_wr_data,
  input  logic [IDX_W-1:0]  tbl_rd_idx,
  input  logic              tbl_rd_hi,
  output logic [31:0]       tbl_rd_data,
  input  logic [7:0]        ext_vector,
  output logic              ext_ack,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [7:0]        dlv_dest,
  output logic              dlv_dest_mode,
  output logic [2:0]        dlv_mode,
  output logic [7:0]        dlv_vector,
  output logic              dlv_trig
);
  rte_t                ent [NUM_PINS];
  logic [NUM_PINS-1:0] rack, pend, trig_v, mask_v, elig, below;
  logic                found, take, load;
  logic [IDX_W-1:0]    pidx;
  rte_t                sel;
  msg_t                msg_q;
  logic                valid_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_flat
    assign trig_v[i] = ent[i].trig;
    assign mask_v[i] = ent[i].mask;
  end

  assign elig = pend & ~mask_v & ~(trig_v & rack);
  assign take = !valid_q || dlv_ready;
  assign load = take && found;
  assign sel  = ent[pidx];
  assign ext_ack = load && (sel.mode == DM_EXTPASS);

  intr_rte_table #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_table (
    .clk, .rst_n,
    .wr_en(tbl_wr_en), .wr_idx(tbl_wr_idx), .wr_hi(tbl_wr_hi), .wr_data(tbl_wr_data),
    .rack_set(load && sel.trig), .rack_idx(pidx),
    .eoi_valid, .eoi_vector,
    .rd_idx(tbl_rd_idx), .rd_hi(tbl_rd_hi), .rd_data(tbl_rd_data),
    .ent_o(ent), .rack_o(rack)
  );

  intr_pending #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W), .REQ_W(REQ_W)) u_pend (
    .clk, .rst_n, .irq_valid, .irq_num, .irq_level,
    .trig(trig_v), .mask(mask_v),
    .dclr_en(load && !sel.trig), .dclr_idx(pidx),
    .pend_o(pend)
  );

  intr_pick #(.NUM_PINS(NUM_PINS), .IDX_W(IDX_W)) u_pick (
    .elig, .found, .idx(pidx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      msg_q   <= '0;
    end else if (load) begin
      valid_q     <= 1'b1;
      msg_q.dest  <= sel.dest;
      msg_q.dmode <= sel.dmode;
      msg_q.mode  <= sel.mode;
      msg_q.trig  <= sel.trig;
      msg_q.vec   <= (sel.mode == DM_EXTPASS) ? ext_vector : sel.vec;
    end else if (dlv_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign dlv_valid     = valid_q;
  assign dlv_dest      = msg_q.dest;
  assign dlv_dest_mode = msg_q.dmode;
  assign dlv_mode      = msg_q.mode;
  assign dlv_vector    = msg_q.vec;
  assign dlv_trig      = msg_q.trig;

  assign below = elig & ~({NUM_PINS{1'b1}} << pidx);

  // R9: a stalled message is held intact
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready) |=> (dlv_valid && $stable(msg_q)));
  // R6: the selected pin is eligible and no lower pin is
  assert_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (elig[pidx] && below == '0));
  // R8: pass-through vector comes from the external controller
  assert_ext_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_ack |=> (dlv_valid && dlv_vector == $past(ext_vector)));
  // R1: nothing is offered right after reset
  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> !dlv_valid);
endmodule

// File: tb/intr_redirect_engine_tb.sv
`timescale 1ns/1ps
module intr_redirect_engine_tb_top;
  localparam int NUM_PINS = 24;
  localparam int REQ_W    = 8;
  localparam int IDX_W    = $clog2(NUM_PINS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic irq_valid = 0, irq_level = 0, eoi_valid = 0;
  logic [REQ_W-1:0] irq_num = '0;
  logic [7:0] eoi_vector = '0, ext_vector = 8'hA7;
  logic tbl_wr_en = 0, tbl_wr_hi = 0, tbl_rd_hi = 0;
  logic [IDX_W-1:0] tbl_wr_idx = '0, tbl_rd_idx = '0;
  logic [31:0] tbl_wr_data = '0, tbl_rd_data;
  logic ext_ack, dlv_valid, dlv_ready = 1'b1, dlv_dest_mode, dlv_trig;
  logic [7:0] dlv_dest, dlv_vector;
  logic [2:0] dlv_mode;

  int checks = 0, fails = 0, ack_cnt = 0;
  bit done = 0;

  always #4 clk = ~clk;

  intr_redirect_engine #(.NUM_PINS(NUM_PINS), .REQ_W(REQ_W)) dut_i (.*);

  always @(posedge clk) if (rst_n && ext_ack) ack_cnt++;

  // {request number, expected pin}; 8'hFF means no delivery
  localparam logic [15:0] VEC_TBL [6] = '{
    {8'd1, 8'd1}, {8'd0, 8'd2}, {8'd2, 8'd2},
    {8'd23, 8'd23}, {8'd24, 8'hFF}, {8'd200, 8'hFF}};

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] lo_word(logic [7:0] p, bit trg, bit msk,
                                          logic [2:0] md, logic [7:0] v);
    return {15'h0, msk, trg, 1'b0, 2'b00, p[0], md, v};
  endfunction

  task automatic wr(logic [IDX_W-1:0] idx, bit hi, logic [31:0] d);
    tbl_wr_en = 1; tbl_wr_idx = idx; tbl_wr_hi = hi; tbl_wr_data = d;
    @(negedge clk);
    tbl_wr_en = 0;
  endtask

  task automatic prog(logic [7:0] p, bit trg, bit msk, logic [2:0] md, logic [7:0] v);
    wr(IDX_W'(p), 1'b1, {p * 8'd3, 24'h0});
    wr(IDX_W'(p), 1'b0, lo_word(p, trg, msk, md, v));
  endtask

  task automatic rd(logic [IDX_W-1:0] idx, bit hi, output logic [31:0] d);
    tbl_rd_idx = idx; tbl_rd_hi = hi;
    #1 d = tbl_rd_data;
  endtask

  task automatic irq(logic [REQ_W-1:0] n, bit lvl, int cycles = 1);
    irq_valid = 1; irq_num = n; irq_level = lvl;
    repeat (cycles) @(negedge clk);
    irq_valid = 0;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1; eoi_vector = v;
    @(negedge clk);
    eoi_valid = 0;
  endtask

  // checks the next offered beat; returns after the edge that consumes it
  task automatic expect_dlv(string tag, logic [7:0] dest, bit dm, logic [2:0] md,
                            logic [7:0] v, bit trg);
    int n = 0;
    while (!dlv_valid && n < 20) begin @(negedge clk); n++; end
    check(dlv_valid, {tag, " valid"}, 32'(dlv_valid), 32'd1);
    check({dlv_dest, dlv_dest_mode, dlv_mode, dlv_vector, dlv_trig} == {dest, dm, md, v, trg},
          {tag, " payload"},
          32'({dlv_dest, dlv_dest_mode, dlv_mode, dlv_vector, dlv_trig}),
          32'({dest, dm, md, v, trg}));
    @(negedge clk);
  endtask

  task automatic expect_none(string tag, int cycles);
    bit seen = 0;
    repeat (cycles) begin @(negedge clk); if (dlv_valid) seen = 1; end
    check(!seen, tag, 32'(seen), 32'd0);
  endtask

  task automatic expect_pin(string tag, logic [7:0] p);
    expect_dlv(tag, p * 8'd3, p[0], {1'b0, p[1:0]}, 8'h40 + p, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(!dlv_valid, "R1 idle", 32'(dlv_valid), 0);
    rd(5, 0, d); check(d == 32'h0001_0000, "R1 entry masked", d, 32'h0001_0000);
    expect_none("R1 nothing pending", 4);

    foreach (VEC_TBL[k]) begin end
    prog(1, 0, 0, 3'd1, 8'h41); prog(2, 0, 0, 3'd2, 8'h42); prog(3, 0, 0, 3'd3, 8'h43);
    prog(7, 0, 0, 3'd3, 8'h47); prog(23, 0, 0, 3'd3, 8'h57);

    // R7 read-back layout
    rd(23, 1, d); check(d == 32'h4500_0000, "R7 high word", d, 32'h4500_0000);
    rd(7, 0, d); check(d == lo_word(7, 0, 0, 3, 8'h47), "R7 low word", d, lo_word(7, 0, 0, 3, 8'h47));

    // R2/R7 routing table walk
    for (int k = 0; k < 6; k++) begin
      logic [7:0] n, p;
      {n, p} = VEC_TBL[k];
      irq(n, 1);
      if (p == 8'hFF) expect_none("R2 out-of-range ignored", 6);
      else            expect_pin("R2 R7 routed delivery", p);
    end

    // R3 masked edge request is dropped for good
    wr(3, 0, lo_word(3, 0, 1, 3, 8'h43));
    irq(3, 1);
    expect_none("R3 masked no delivery", 4);
    wr(3, 0, lo_word(3, 0, 0, 3, 8'h43));
    expect_none("R3 dropped after unmask", 6);

    // R9 stall and R6 ascending order
    dlv_ready = 0;
    irq(23, 1); irq(7, 1); irq(1, 1);
    @(negedge clk);
    check(dlv_valid && dlv_vector == 8'h57, "R9 held message", 32'(dlv_vector), 32'h57);
    repeat (3) @(negedge clk);
    check(dlv_valid && dlv_vector == 8'h57 && dlv_dest == 8'd69, "R9 stable payload",
          32'({dlv_vector, dlv_dest}), 32'({8'h57, 8'd69}));
    dlv_ready = 1;
    expect_pin("R9 released beat", 23);
    expect_pin("R6 lowest first", 1);
    expect_pin("R6 then higher", 7);
    expect_none("R9 one per beat", 4);

    // R3 request in the delivery cycle re-arms the pin
    irq(1, 1, 2);
    expect_pin("R3 first delivery", 1);
    expect_pin("R3 same-cycle request wins", 1);
    expect_none("R3 edge pending cleared", 4);

    // R4 / R5 level pin
    prog(5, 1, 0, 3'd0, 8'h55);
    irq(5, 1);
    expect_dlv("R4 level delivery", 8'd15, 1'b1, 3'd0, 8'h55, 1'b1);
    rd(5, 0, d); check(d[14], "R4 remote-ack set", d, d | 32'h4000);
    expect_none("R4 no repeat while acked", 6);
    eoi(8'h56);
    expect_none("R5 other vector no effect", 4);
    rd(5, 0, d); check(d[14], "R5 ack kept on mismatch", 32'(d[14]), 1);
    eoi(8'h55);
    expect_dlv("R5 redelivered after EOI", 8'd15, 1'b1, 3'd0, 8'h55, 1'b1);
    irq(5, 0);
    eoi(8'h55);
    expect_none("R4 low level clears pending", 4);
    rd(5, 0, d); check(!d[14], "R5 ack cleared", 32'(d[14]), 0);

    // R8 pass-through vector
    prog(9, 0, 0, 3'b111, 8'h99);
    irq(9, 1);
    expect_dlv("R8 external vector", 8'd27, 1'b1, 3'b111, 8'hA7, 1'b0);
    check(ack_cnt == 1, "R8 one acknowledge", ack_cnt, 1);

    // R10 remote-ack not writable
    wr(4, 0, 32'h0000_4044);
    rd(4, 0, d); check(d == 32'h0000_0044, "R10 ack bit read-only", d, 32'h44);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule